// File: doc/BRIEF.md
# Mixed-Sign Operand Multiplier

This block multiplies two W-bit operands and presents their 2W-bit product on a register one clock after a request is accepted. Each operand has its own signedness flag, so one instance covers unsigned by unsigned, signed by signed and either mixed combination. No separate datapath exists per combination.

Each operand is first widened by one bit. A signed operand copies its top bit into the new bit. An unsigned operand gets a zero there. A single (W+1)x(W+1) two's-complement multiply then produces a value that is correct for every combination, and the low 2W bits of that value are stored. The caller pulses a valid strobe with the operands and flags, and reads the product when the output strobe rises on the following cycle.

A two-state output machine tracks whether the result register holds a fresh product:
- OUT_IDLE to OUT_LIVE on a cycle with the input strobe high.
- OUT_LIVE to OUT_LIVE on back-to-back requests.
- OUT_LIVE to OUT_IDLE when the strobe is low.
- OUT_IDLE to OUT_IDLE while no request arrives.
- Reset forces OUT_IDLE from either state.

Top module: `mxs_mul`

## Requirements
- R1: A synchronous active-high reset sampled on a clock edge leaves `prod_o` at zero and `vld_o` low after that edge.
- R2: `vld_o` is high in exactly the cycle after an edge that sampled `vld_i` high, and low after an edge that sampled `vld_i` low.
- R3: With both sign flags at 0 (1 means signed, 0 means unsigned), `prod_o` equals the unsigned product of the two operands, for example 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R4: With both sign flags at 1, `prod_o` equals the two's-complement product, for example 0x8000 times 0x8000 gives 0x40000000 and 0xFFFF times 0xFFFF gives 0x00000001.
- R5: With `a_sgn_i`=1 and `b_sgn_i`=0, `prod_o` is the two's-complement encoding of signed a times unsigned b, for example 0xFFFF times 0xFFFF gives 0xFFFF0001.
- R6: With `a_sgn_i`=0 and `b_sgn_i`=1, `prod_o` is the two's-complement encoding of unsigned a times signed b, for example 0xFFFF times 0x8000 gives 0x80008000.
- R7: On an edge with `vld_i` low, `prod_o` keeps its previous value, whatever the operands and flags are doing.
- R8: The product is exact for every operand width W: the result is 2W bits wide, and no operand pair in any sign combination overflows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Request strobe; operands sampled when high |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| a_sgn_i | input | 1 | 1: treat `a_i` as signed; 0: unsigned |
| b_sgn_i | input | 1 | 1: treat `b_i` as signed; 0: unsigned |
| prod_o | output | 2W | Registered product |
| vld_o | output | 1 | High the cycle after a request was sampled |

## Verification
The bench builds two instances.

The first uses the default W=16. It is driven with the extreme corners (0x8000, 0x7FFF, 0xFFFF, 0x0000) under all four sign combinations, plus a pseudo-random stream with back-to-back requests and idle gaps.

The second uses W=4. At that width the full space is only 16x16 operand pairs times four sign modes, so it is swept exhaustively. Every widening corner, including the most negative by the largest unsigned value, is then checked rather than sampled.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

    // Output-register occupancy machine
    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_LIVE = 1'b1
    } out_state_e;

    // Operand index for the widening stage
    localparam int unsigned OPND_A = 0;
    localparam int unsigned OPND_B = 1;
    localparam int unsigned OPND_N = 2;

endpackage

// File: rtl/mxs_widen.sv
// Widens one operand by one bit: sign copy when signed, zero when unsigned.
module mxs_widen #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] op_i,
    input  logic         sgn_i,
    output logic [W:0]   wide_o
);
    logic top_bit;

    always_comb begin
        top_bit = sgn_i & op_i[W-1];
        wide_o  = {top_bit, op_i};
    end
endmodule

// File: rtl/mxs_array.sv
// One (W+1)x(W+1) two's-complement array serving all sign combinations.
module mxs_array #(
    parameter int unsigned W = 16
) (
    input  logic [W:0]     a_w_i,
    input  logic [W:0]     b_w_i,
    output logic [2*W-1:0] prod_o
);
    localparam int unsigned EW = W + 1;
    localparam int unsigned FW = 2 * EW;
    localparam int unsigned PW = 2 * W;

    logic signed [FW-1:0] full;

    always_comb begin
        full   = $signed(a_w_i) * $signed(b_w_i);
        prod_o = full[PW-1:0];
    end

    // R8: widened operands lie in [-2^(W-1), 2^W-1], so the two spare
    // top bits of the full product always agree; nothing is lost.
    always_comb begin
        spare_bits_chk: assert (full[FW-1] == full[FW-2])
            else $error("spare product bits disagree");
    end
endmodule

// File: rtl/mxs_mul.sv
module mxs_mul #(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           vld_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           a_sgn_i,
    input  logic           b_sgn_i,
    output logic [2*W-1:0] prod_o,
    output logic           vld_o
);
    import mxs_pkg::*;

    localparam int unsigned EW = W + 1;
    localparam int unsigned PW = 2 * W;

    logic [W-1:0]  opnd   [OPND_N];
    logic          opsgn  [OPND_N];
    logic [EW-1:0] wide   [OPND_N];
    logic [PW-1:0] comb_prod;

    out_state_e state_q, state_d;
    logic [PW-1:0] prod_q;

    always_comb begin
        opnd[OPND_A]  = a_i;
        opnd[OPND_B]  = b_i;
        opsgn[OPND_A] = a_sgn_i;
        opsgn[OPND_B] = b_sgn_i;
    end

    for (genvar g = 0; g < OPND_N; g++) begin : g_widen
        mxs_widen #(.W(W)) u_widen (
            .op_i   (opnd[g]),
            .sgn_i  (opsgn[g]),
            .wide_o (wide[g])
        );
    end

    mxs_array #(.W(W)) u_array (
        .a_w_i  (wide[OPND_A]),
        .b_w_i  (wide[OPND_B]),
        .prod_o (comb_prod)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: if (vld_i)  state_d = OUT_LIVE;
            OUT_LIVE: if (!vld_i) state_d = OUT_IDLE;
            default:              state_d = OUT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_IDLE;
        else     state_q <= state_d;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (rst)        prod_q <= '0;
        else if (vld_i) prod_q <= comb_prod;
    end

    always_comb begin
        prod_o = prod_q;
        vld_o  = (state_q == OUT_LIVE);
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (prod_o == '0 && !vld_o));

    // R2
    vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);

    // R2
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(prod_o));

    // R3
    zero_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && (a_i == '0 || b_i == '0)) |=> (prod_o == '0));

    // R4
    signed_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && a_sgn_i && b_sgn_i && a_i != '0 && b_i != '0)
        |=> (prod_o[PW-1] == ($past(a_i[W-1]) ^ $past(b_i[W-1]))));

    // R5
    mixed_a_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && a_sgn_i && !b_sgn_i && a_i != '0 && b_i != '0)
        |=> (prod_o[PW-1] == $past(a_i[W-1])));

    // R6
    mixed_b_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !a_sgn_i && b_sgn_i && a_i != '0 && b_i != '0)
        |=> (prod_o[PW-1] == $past(b_i[W-1])));
endmodule

// File: tb/sim_mxs_mul.sv
module sim_mxs_mul;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        vld_i = 1'b0;
    logic [15:0] a_i = '0, b_i = '0;
    logic        a_sgn_i = 1'b0, b_sgn_i = 1'b0;
    logic [31:0] prod_o;
    logic        vld_o;

    logic        s_vld = 1'b0;
    logic [3:0]  s_a = '0, s_b = '0;
    logic        s_as = 1'b0, s_bs = 1'b0;
    logic [7:0]  s_prod;
    logic        s_vo;

    mxs_mul #(.W(16)) u0 (
        .clk(clk), .rst(rst), .vld_i(vld_i), .a_i(a_i), .b_i(b_i),
        .a_sgn_i(a_sgn_i), .b_sgn_i(b_sgn_i), .prod_o(prod_o), .vld_o(vld_o));

    mxs_mul #(.W(4)) u1 (
        .clk(clk), .rst(rst), .vld_i(s_vld), .a_i(s_a), .b_i(s_b),
        .a_sgn_i(s_as), .b_sgn_i(s_bs), .prod_o(s_prod), .vld_o(s_vo));

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       req_q[$];
    logic [31:0] last_prod = '0;
    logic        mon_en = 1'b0;

    function automatic longint widen(logic [15:0] v, bit s, int w);
        longint x = longint'(v);
        if (s && v[w-1]) x = x - (longint'(1) << w);
        return x;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic drive(logic [15:0] a, logic [15:0] b, bit sa, bit sb, string req);
        longint p;
        @(negedge clk);
        vld_i = 1'b1; a_i = a; b_i = b; a_sgn_i = sa; b_sgn_i = sb;
        p = widen(a, sa, 16) * widen(b, sb, 16);
        exp_q.push_back(p[31:0]);
        req_q.push_back(req);
    endtask

    task automatic idle(int n, logic [15:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld_i = 1'b0; a_i = junk ^ 16'(i); b_i = ~junk; a_sgn_i = i[0]; b_sgn_i = i[1];
        end
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (vld_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", 1, 0);
                end else begin
                    logic [31:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(prod_o == e, r, prod_o, e);
                end
                last_prod = prod_o;
            end else begin
                check(prod_o == last_prod, "R7", prod_o, last_prod);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(prod_o == 32'h0, "R1", prod_o, 0);
        check(vld_o == 1'b0, "R1", vld_o, 0);
        rst = 1'b0;
        mon_en = 1'b1;

        // R3 unsigned corners
        drive(16'hFFFF, 16'hFFFF, 0, 0, "R3");
        drive(16'h8000, 16'h0002, 0, 0, "R3");
        drive(16'h0000, 16'hFFFF, 0, 0, "R3");
        // R4 signed corners
        drive(16'h8000, 16'h8000, 1, 1, "R4");
        drive(16'hFFFF, 16'hFFFF, 1, 1, "R4");
        drive(16'h7FFF, 16'h8000, 1, 1, "R4");
        drive(16'h7FFF, 16'h7FFF, 1, 1, "R4");
        // R5 signed a, unsigned b
        drive(16'hFFFF, 16'hFFFF, 1, 0, "R5");
        drive(16'h8000, 16'hFFFF, 1, 0, "R5");
        // R6 unsigned a, signed b
        drive(16'hFFFF, 16'h8000, 0, 1, "R6");
        drive(16'hFFFF, 16'hFFFF, 0, 1, "R6");
        idle(4, 16'h5A5A);   // R7: outputs hold through idle

        // pseudo-random stream with gaps
        for (int i = 0; i < 400; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            unique case (lfsr[1:0])
                2'd0: drive(lfsr[31:16], lfsr[23:8], 0, 0, "R3");
                2'd1: drive(lfsr[31:16], lfsr[23:8], 1, 1, "R4");
                2'd2: drive(lfsr[31:16], lfsr[23:8], 1, 0, "R5");
                default: drive(lfsr[31:16], lfsr[23:8], 0, 1, "R6");
            endcase
            if (lfsr[4:2] == 3'd0) idle(int'(lfsr[6:5]) + 1, lfsr[15:0]);
        end
        idle(3, 16'h1234);
        // R2: every request produced exactly one valid result
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);

        // R1: mid-run reset clears the register
        drive(16'h1234, 16'h5678, 0, 0, "R3");
        @(negedge clk);
        mon_en = 1'b0;
        vld_i = 1'b1; rst = 1'b1;
        @(negedge clk);
        check(prod_o == 32'h0, "R1", prod_o, 0);
        check(vld_o == 1'b0, "R1", vld_o, 0);
        rst = 1'b0; vld_i = 1'b0;
        exp_q.delete(); req_q.delete();

        // R8: exhaustive sweep of the narrow instance
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    longint p;
                    @(negedge clk);
                    s_vld = 1'b1; s_a = 4'(a); s_b = 4'(b); s_as = m[0]; s_bs = m[1];
                    p = widen(16'(a), m[0], 4) * widen(16'(b), m[1], 4);
                    @(negedge clk);
                    s_vld = 1'b0;
                    check(s_vo == 1'b1 && s_prod == p[7:0], "R8", s_prod, p[7:0]);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule